// File: doc/BRIEF.md
# Modem DTE Interchange Circuit Controller

This block drives the digital side of the interchange circuits between a synchronous modem and its data terminal. On the transmit side it makes a transmit bit clock and picks the clock that samples terminal data. The choices are this internal clock and a clock that the terminal supplies. Each sampled bit goes to the modem datapath as a valid/ready stream. On the receive side it takes bits from the modem datapath as a valid/ready stream. It presents each bit to the terminal with a receive bit clock that it generates.

The block also generates clear-to-send from request-to-send. It holds clear-to-send off while the modem is starting up or retraining. Once in the data phase, clear-to-send follows request-to-send after a fixed, parameterised number of system clocks. Carrier detect is a registered decode of the modem's operating-sequence state, so it only moves at sequence boundaries. In character (non-synchronous) mode, the terminal-sourced transmit clock is disregarded and the receive bit clock pin is clamped low.

Stream rules: the transmit stream holds `tx_valid_o` and `tx_data_o` until `tx_ready_i` is seen. A newer sample that arrives while a bit is still waiting replaces it, so the consumer must accept one bit per bit period. The receive stream accepts a bit only while `rx_ready_o` is high, and the block holds one bit at a time.

Top module: `dte_circuit_ctl`

## Requirements
- R1: During and directly after reset: `cts_o`=0, `dcd_o`=0, `tx_valid_o`=0, `rx_ready_o`=1, `rxd_o`=1 (mark), `tx_timing_o`=0, `rx_timing_o`=0.
- R2: With `seq_state`=2 (data phase), `cts_o` takes the value of `rts_i` exactly CTS_DELAY clock edges after `rts_i` changes and then stays stable. A change of `rts_i` that reverts before CTS_DELAY edges leaves `cts_o` unchanged. CTS_DELAY times the clock period must not exceed 2 ms.
- R3: Whenever `seq_state` is not 2, `cts_o` is 0 from the next clock edge on, whatever `rts_i` is. This covers 0 idle, 1 start-up, 3 retrain and 4 clear-down.
- R4: `dcd_o` is 1 one edge after `seq_state` is 2 or 3, and 0 one edge after any other state.
- R5: `tx_timing_o` is a square wave with a period of 2*TX_HALF clocks, starting low after reset.
- R6: With the internal source in use and `cts_o`=1, the edge at which `tx_timing_o` rises captures `txd_i` into `tx_data_o` and sets `tx_valid_o`.
- R7: With the external source in use (`ext_clk_sel`=1 latched, `sync_mode`=1), a rising edge of `tx_ext_clk_i` captures `txd_i` after a two-stage synchronizer. `tx_valid_o` rises on the third clock edge after the input rises, and internal clock rises capture nothing.
- R8: `ext_clk_sel` is taken into the source register only while `cts_o`=0; changes while `cts_o`=1 have no effect until it drops.
- R9: With `sync_mode`=0, `tx_ext_clk_i` is ignored and the internal clock samples transmit data even if the external source is latched.
- R10: With `sync_mode`=0, `rx_timing_o` is 0 from the next clock edge on.
- R11: The receive side holds one bit. `rx_ready_o` falls after an accepted bit. The bit appears on `rxd_o` at the next falling edge of `rx_timing_o`. If no bit is held, `rxd_o` returns to 1 at that edge.
- R12: `tx_valid_o` stays 1 while `tx_ready_i`=0; a new capture meanwhile replaces `tx_data_o`; `tx_valid_o` clears one edge after `tx_ready_i`=1 with no new capture.
- R13: In synchronous mode `rx_timing_o` is a square wave with a period of 2*RX_HALF clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 1 synchronous interface, 0 character mode |
| seq_state | input | 3 | Operating sequence: 0 idle, 1 start-up, 2 data, 3 retrain, 4 clear-down |
| ext_clk_sel | input | 1 | 1 requests terminal-sourced transmit timing |
| rts_i | input | 1 | Request to send |
| cts_o | output | 1 | Clear to send |
| dcd_o | output | 1 | Received carrier detect |
| txd_i | input | 1 | Transmit data from terminal |
| tx_ext_clk_i | input | 1 | Terminal-sourced transmit timing (asynchronous) |
| tx_timing_o | output | 1 | Modem-sourced transmit timing |
| tx_valid_o | output | 1 | Transmit bit stream valid |
| tx_ready_i | input | 1 | Transmit bit stream ready |
| tx_data_o | output | 1 | Transmit bit stream data |
| rx_valid_i | input | 1 | Receive bit stream valid |
| rx_ready_o | output | 1 | Receive bit stream ready |
| rx_data_i | input | 1 | Receive bit stream data |
| rxd_o | output | 1 | Receive data to terminal |
| rx_timing_o | output | 1 | Modem-sourced receive timing |

## Verification
The assertions assume that every input except `tx_ext_clk_i` is synchronous to `clk`. They also assume that `seq_state` only carries the encodings listed. The stimulus changes all inputs on the falling clock edge. It holds each level of `tx_ext_clk_i` for at least three clocks so the synchronizer sees every edge. Tests of the external-clock path keep `tx_ext_clk_i` static whenever an internal clock rise falls in the observed window. This keeps captures unambiguous.

// File: rtl/dte_ctl_pkg.sv
package dte_ctl_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE    = 3'd0,
    SEQ_STARTUP = 3'd1,
    SEQ_DATA    = 3'd2,
    SEQ_RETRAIN = 3'd3,
    SEQ_CLEAR   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/half_period_div.sv
module half_period_div #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic q,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = (cnt == CW'(HALF - 1));
  assign rise_tick = wrap & ~q;
  assign fall_tick = wrap & q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      q   <= ~q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  rise_sets_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> q);
endmodule

// File: rtl/flow_ctl.sv
module flow_ctl
  import dte_ctl_pkg::*;
#(
  parameter int CTS_DELAY = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state,
  input  logic       rts,
  output logic       cts,
  output logic       dcd
);
  localparam int CW = $clog2(CTS_DELAY + 1);

  logic [CW-1:0] cnt;
  logic          in_data;

  assign in_data = (state == SEQ_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n || !in_data) begin
      cts <= 1'b0;
      cnt <= '0;
    end else if (rts != cts) begin
      if (cnt == CW'(CTS_DELAY - 1)) begin
        cts <= rts;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dcd <= 1'b0;
    else        dcd <= (state == SEQ_DATA) || (state == SEQ_RETRAIN);
  end

  // R3
  cts_off_outside_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SEQ_DATA) |=> !cts);
  // R2
  cts_rise_needs_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts) |-> $past(rts));
  // R2
  cts_fall_needs_rts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cts) |-> (!$past(rts) || ($past(state) != SEQ_DATA)));
  // R4
  dcd_rise_at_sequence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dcd) |-> (($past(state) == SEQ_DATA) || ($past(state) == SEQ_RETRAIN)));
endmodule

// File: rtl/tx_path.sv
module tx_path #(
  parameter int TX_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic ext_sel,
  input  logic cts,
  input  logic txd,
  input  logic ext_clk,
  input  logic tx_ready,
  output logic tx_timing,
  output logic tx_valid,
  output logic tx_data
);
  localparam int SYNC_STAGES = 3;

  logic                   int_rise;
  logic                   int_fall;
  logic [SYNC_STAGES-1:0] clk_sh;
  logic [1:0]             dat_sh;
  logic                   src_ext;
  logic                   use_ext;
  logic                   ext_rise;
  logic                   capture;
  logic                   cap_bit;

  half_period_div #(.HALF(TX_HALF)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .q         (tx_timing),
    .rise_tick (int_rise),
    .fall_tick (int_fall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sh <= '0;
      dat_sh <= '0;
    end else begin
      clk_sh <= {clk_sh[SYNC_STAGES-2:0], ext_clk};
      dat_sh <= {dat_sh[0], txd};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   src_ext <= 1'b0;
    else if (!cts) src_ext <= ext_sel;
  end

  assign use_ext  = src_ext & sync_mode;
  assign ext_rise = clk_sh[1] & ~clk_sh[2];
  assign capture  = cts & (use_ext ? ext_rise : int_rise);
  assign cap_bit  = use_ext ? dat_sh[1] : txd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= 1'b0;
    end else if (capture) begin
      tx_valid <= 1'b1;
      tx_data  <= cap_bit;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  // R8
  src_frozen_while_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cts |=> $stable(src_ext));
  // R12
  valid_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid);
  // R5
  timing_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_fall |=> !tx_timing);
endmodule

// File: rtl/rx_path.sv
module rx_path #(
  parameter int RX_HALF = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic rx_valid,
  input  logic rx_data,
  output logic rx_ready,
  output logic rxd,
  output logic rx_timing
);
  logic div_q;
  logic rise_tick;
  logic fall_tick;
  logic full;
  logic hold;
  logic accept;

  half_period_div #(.HALF(RX_HALF)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .q         (div_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  assign rx_ready = ~full;
  assign accept   = rx_valid & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= 1'b1;
      rxd  <= 1'b1;
    end else begin
      if (fall_tick) rxd <= full ? hold : 1'b1;
      if (accept) begin
        full <= 1'b1;
        hold <= rx_data;
      end else if (fall_tick) begin
        full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rx_timing <= 1'b0;
    else        rx_timing <= sync_mode & div_q;
  end

  // R10
  rx_timing_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |=> !rx_timing);
  // R11
  one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_ready);
  // R13
  rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_tick && sync_mode) |=> ##1 rx_timing);
endmodule

// File: rtl/dte_circuit_ctl.sv
module dte_circuit_ctl
  import dte_ctl_pkg::*;
#(
  parameter int CTS_DELAY = 16,
  parameter int TX_HALF   = 4,
  parameter int RX_HALF   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_mode,
  input  logic [2:0] seq_state,
  input  logic       ext_clk_sel,
  input  logic       rts_i,
  output logic       cts_o,
  output logic       dcd_o,
  input  logic       txd_i,
  input  logic       tx_ext_clk_i,
  output logic       tx_timing_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic       tx_data_o,
  input  logic       rx_valid_i,
  output logic       rx_ready_o,
  input  logic       rx_data_i,
  output logic       rxd_o,
  output logic       rx_timing_o
);
  seq_state_e state;
  assign state = seq_state_e'(seq_state);

  flow_ctl #(.CTS_DELAY(CTS_DELAY)) u_flow (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .rts   (rts_i),
    .cts   (cts_o),
    .dcd   (dcd_o)
  );

  tx_path #(.TX_HALF(TX_HALF)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .ext_sel   (ext_clk_sel),
    .cts       (cts_o),
    .txd       (txd_i),
    .ext_clk   (tx_ext_clk_i),
    .tx_ready  (tx_ready_i),
    .tx_timing (tx_timing_o),
    .tx_valid  (tx_valid_o),
    .tx_data   (tx_data_o)
  );

  rx_path #(.RX_HALF(RX_HALF)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .rx_valid  (rx_valid_i),
    .rx_data   (rx_data_i),
    .rx_ready  (rx_ready_o),
    .rxd       (rxd_o),
    .rx_timing (rx_timing_o)
  );

  // R6
  no_capture_without_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_o && !tx_valid_o) |=> !tx_valid_o);
endmodule

// File: tb/dte_circuit_ctl_tb.sv
module dte_circuit_ctl_tb;
  localparam int CTS_DELAY = 16;
  localparam int TX_HALF   = 4;
  localparam int RX_HALF   = 5;
  localparam int CLK_NS    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b1;
  logic [2:0] seq_state = 3'd0;
  logic ext_clk_sel = 1'b0;
  logic rts_i = 1'b0;
  logic txd_i = 1'b0;
  logic tx_ext_clk_i = 1'b0;
  logic tx_ready_i = 1'b1;
  logic rx_valid_i = 1'b0;
  logic rx_data_i = 1'b0;
  logic cts_o, dcd_o, tx_timing_o, tx_valid_o, tx_data_o;
  logic rx_ready_o, rxd_o, rx_timing_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dte_circuit_ctl #(.CTS_DELAY(CTS_DELAY), .TX_HALF(TX_HALF), .RX_HALF(RX_HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .seq_state(seq_state),
    .ext_clk_sel(ext_clk_sel), .rts_i(rts_i), .cts_o(cts_o), .dcd_o(dcd_o),
    .txd_i(txd_i), .tx_ext_clk_i(tx_ext_clk_i), .tx_timing_o(tx_timing_o),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
    .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o), .rx_data_i(rx_data_i),
    .rxd_o(rxd_o), .rx_timing_o(rx_timing_o)
  );

  typedef struct packed {
    logic [2:0] st;
    logic       rts;
    logic [7:0] n;
    logic       cts;
    logic       dcd;
  } vec_t;

  // rows: R3 start-up, R2 rise timing, R2 short glitch, R2 fall, R3 retrain, R4 decode
  localparam vec_t VEC [11] = '{
    '{3'd1, 1'b1, 8'd20, 1'b0, 1'b0},
    '{3'd2, 1'b1, 8'd15, 1'b0, 1'b1},
    '{3'd2, 1'b1, 8'd1,  1'b1, 1'b1},
    '{3'd2, 1'b0, 8'd5,  1'b1, 1'b1},
    '{3'd2, 1'b1, 8'd5,  1'b1, 1'b1},
    '{3'd2, 1'b0, 8'd16, 1'b0, 1'b1},
    '{3'd2, 1'b1, 8'd16, 1'b1, 1'b1},
    '{3'd3, 1'b1, 8'd1,  1'b0, 1'b1},
    '{3'd2, 1'b1, 8'd16, 1'b1, 1'b1},
    '{3'd4, 1'b1, 8'd1,  1'b0, 1'b0},
    '{3'd0, 1'b0, 8'd2,  1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tx_rise();
    int k = 0;
    while (tx_timing_o !== 1'b0 && k < 100) begin @(negedge clk); k++; end
    while (tx_timing_o !== 1'b1 && k < 100) begin @(negedge clk); k++; end
  endtask

  task automatic wait_rx_rise();
    int k = 0;
    while (rx_timing_o !== 1'b0 && k < 100) begin @(negedge clk); k++; end
    while (rx_timing_o !== 1'b1 && k < 100) begin @(negedge clk); k++; end
  endtask

  task automatic wait_rx_fall();
    int k = 0;
    while (rx_timing_o !== 1'b1 && k < 100) begin @(negedge clk); k++; end
    while (rx_timing_o !== 1'b0 && k < 100) begin @(negedge clk); k++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int per;
    logic seen;
    // R2 delay budget: 2 ms at the bench clock
    chk("R2 delay within 2 ms", (CTS_DELAY * CLK_NS <= 2000000), 1);

    cyc(3);
    chk("R1 cts", cts_o, 0);
    chk("R1 dcd", dcd_o, 0);
    chk("R1 tx_valid", tx_valid_o, 0);
    chk("R1 rx_ready", rx_ready_o, 1);
    chk("R1 rxd mark", rxd_o, 1);
    chk("R1 tx_timing", tx_timing_o, 0);
    chk("R1 rx_timing", rx_timing_o, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 11; i++) begin
      seq_state = VEC[i].st;
      rts_i     = VEC[i].rts;
      cyc(int'(VEC[i].n));
      chk($sformatf("R2/R3 cts row %0d", i), cts_o, VEC[i].cts);
      chk($sformatf("R4 dcd row %0d", i), dcd_o, VEC[i].dcd);
    end

    // enter data phase with internal timing
    seq_state = 3'd2; ext_clk_sel = 1'b0; rts_i = 1'b1;
    cyc(CTS_DELAY + 1);
    chk("R2 cts on", cts_o, 1);

    // R5 period of transmit timing
    wait_tx_rise();
    per = 0;
    while (tx_timing_o !== 1'b0 && per < 100) begin @(negedge clk); per++; end
    while (tx_timing_o !== 1'b1 && per < 100) begin @(negedge clk); per++; end
    chk("R5 tx period", per, 2 * TX_HALF);

    // R6 internal capture, R12 hold and replace
    tx_ready_i = 1'b0; txd_i = 1'b1;
    wait_tx_rise();
    chk("R6 valid at rise", tx_valid_o, 1);
    chk("R6 data at rise", tx_data_o, 1);
    txd_i = 1'b0;
    cyc(2);
    chk("R12 valid held", tx_valid_o, 1);
    wait_tx_rise();
    chk("R12 replaced data", tx_data_o, 0);
    tx_ready_i = 1'b1;
    cyc(1);
    chk("R12 valid cleared", tx_valid_o, 0);

    // R8 select change while cts on is ignored
    ext_clk_sel = 1'b1; txd_i = 1'b1;
    cyc(1);
    wait_tx_rise();
    chk("R8 internal still used", tx_valid_o, 1);
    chk("R8 data", tx_data_o, 1);

    // R7 re-latch external source while cts off
    rts_i = 1'b0;
    cyc(CTS_DELAY + 1);
    rts_i = 1'b1;
    cyc(CTS_DELAY + 1);
    tx_ready_i = 1'b0; txd_i = 1'b1; tx_ext_clk_i = 1'b1;
    cyc(2);
    chk("R7 not yet valid", tx_valid_o, 0);
    cyc(1);
    chk("R7 valid third edge", tx_valid_o, 1);
    chk("R7 data", tx_data_o, 1);
    txd_i = 1'b0;
    cyc(12);
    chk("R7 internal rises ignored", tx_data_o, 1);
    tx_ext_clk_i = 1'b0; tx_ready_i = 1'b1;
    cyc(4);

    // R9 character mode ignores terminal clock
    sync_mode = 1'b0; txd_i = 1'b1;
    cyc(1);
    wait_tx_rise();
    chk("R9 internal capture", tx_valid_o, 1);
    chk("R9 data", tx_data_o, 1);
    cyc(1);
    tx_ready_i = 1'b0; txd_i = 1'b0; tx_ext_clk_i = 1'b1;
    cyc(3);
    chk("R9 ext edge ignored", tx_valid_o, 0);
    tx_ext_clk_i = 1'b0; tx_ready_i = 1'b1;

    // R10 receive timing clamped
    cyc(1);
    seen = 1'b0;
    for (int k = 0; k < 25; k++) begin
      if (rx_timing_o !== 1'b0) seen = 1'b1;
      cyc(1);
    end
    chk("R10 rx timing clamped", seen, 0);
    sync_mode = 1'b1;

    // R13 receive period
    wait_rx_rise();
    per = 0;
    while (rx_timing_o !== 1'b0 && per < 100) begin @(negedge clk); per++; end
    while (rx_timing_o !== 1'b1 && per < 100) begin @(negedge clk); per++; end
    chk("R13 rx period", per, 2 * RX_HALF);

    // R11 one bit presented at falling edge, then mark
    chk("R11 ready before push", rx_ready_o, 1);
    rx_valid_i = 1'b1; rx_data_i = 1'b0;
    cyc(1);
    rx_valid_i = 1'b0;
    chk("R11 ready drops", rx_ready_o, 0);
    wait_rx_fall();
    chk("R11 rxd bit", rxd_o, 0);
    chk("R11 ready back", rx_ready_o, 1);
    wait_rx_rise();
    wait_rx_fall();
    chk("R11 rxd mark when empty", rxd_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule